// File: doc/BRIEF.md
# Character On-Screen-Display Row Renderer

The block turns a small character display memory into a dot-rate pixel stream for an on-screen overlay. Software writes 10-bit words into a 128-entry display memory through a write port that may be used at any moment, including while the renderer is reading the same memory. Each word carries a 6-bit character code and four control bits. The code, joined with the current glyph line, addresses an external synchronous glyph memory that returns one 14-dot glyph line per read. The control bits select the background, a background colour and the scaling.

Text rows have no fixed length. Code 63 is a New Line marker. When the renderer reaches it, the rest of the scan line is blank, and the next text row starts at the word that follows the marker. Every scan line of a text row is fetched again from the row's first word. A row is 18 lines tall, or 36 lines when it holds a double-height character. The dot clock drives all logic. HSYNC and VSYNC arrive as dot-clock-synchronous levels of programmable polarity. Each VSYNC returns the renderer to word 0 and line 0 and raises a one-cycle interrupt pulse.

The renderer is one state machine with five states. ST_IDLE waits out VSYNC. ST_SYNC blanks the outputs during HSYNC. ST_PRIME takes three cycles to fill the memory pipeline. ST_DRAW emits dots. ST_BLANK holds the outputs off after a New Line. The transitions are as follows. A VSYNC in any state leads to ST_IDLE. An HSYNC in any state leads to ST_SYNC. The line start leads from ST_IDLE or ST_SYNC to ST_PRIME. When priming completes, ST_PRIME goes to ST_DRAW, or to ST_BLANK if the first word is a New Line. At the last dot of a character, ST_DRAW goes to ST_BLANK if the next word is a New Line; otherwise it stays in ST_DRAW and loads the next character.

Top module: `osd_row_render`

## Requirements
- R1: Right after reset, fg_out and bg_en_out are at their inactive levels, and bg_idx and vsync_irq are 0.
- R2: A line starts at the first rising edge that samples HSYNC inactive after it was active. The first dot of the line is shown in the cycle that follows the fourth rising edge counted from that one. Glyph bit 13 is shown first. A normal character lasts 14 cycles, and successive characters follow with no gap.
- R3: Code 63 in bits [5:0] is New Line. From that point the line is blank up to HSYNC, and the next text row begins at the word after the New Line.
- R4: Every scan line of a text row is read again from the row's first word. The glyph address is {code, glyph line[4:0]}. A row made only of normal characters is 18 lines tall.
- R5: Word bits [8:7] select the scaling: 00 normal, 01 double height, 1x double height and width. A double-height character uses glyph line = row line / 2. A row is 36 lines tall if any character on its first line is double height. In such a row, a normal character is blank (no foreground and no background) on lines 18 to 35.
- R6: A double-width character shows each glyph dot for 2 cycles, so it lasts 28 cycles.
- R7: When word bit 6 is set, bg_en_out is active while that character is shown, and bg_idx equals word bit 9. At all other times bg_idx is 0.
- R8: hs_pol, vs_pol, fg_pol and bg_pol each set the active level of their signal: 1 means active high, 0 means active low.
- R9: A VSYNC raises vsync_irq for exactly one cycle, after the first edge that samples VSYNC active. The outputs stay blank during VSYNC. The next line starts at word 0, line 0.
- R10: The outputs are inactive in the cycle after any edge that samples HSYNC active.
- R11: A word written through the CPU port while display is running is shown on the next scan line that fetches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dot_clk | input | 1 | Dot clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync level |
| vsync_in | input | 1 | Vertical sync level |
| hs_pol | input | 1 | Active level of hsync_in |
| vs_pol | input | 1 | Active level of vsync_in |
| fg_pol | input | 1 | Active level of fg_out |
| bg_pol | input | 1 | Active level of bg_en_out |
| cpu_we | input | 1 | Display memory write strobe |
| cpu_addr | input | 7 | Display memory write address |
| cpu_wdata | input | 10 | Display word: colour[9], scale[8:7], box[6], code[5:0] |
| glyph_addr | output | 11 | Glyph memory address {code, glyph line} |
| glyph_bits | input | 14 | Glyph line data, returned one cycle after the address |
| fg_out | output | 1 | Foreground dot |
| bg_en_out | output | 1 | Programmable background enable |
| bg_idx | output | 1 | Background colour select of the current character |
| vsync_irq | output | 1 | One-cycle pulse per VSYNC |

## Verification
Every pixel result arrives on a fixed schedule after the line-start edge. Three edges fill the display and glyph memory pipeline, and dot d of a character that starts at offset s is shown after edge start+3+s+d. The bench computes that schedule from its own copy of the display memory and the glyph formula, and compares the outputs between edges for 90 cycles of every line. The blanking after HSYNC is checked two edges after HSYNC goes active. The VSYNC pulse is sampled exactly one edge and two edges after VSYNC goes active, and each row change is checked on the exact line where the next row must appear.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int OSD_AW = 7;
    localparam int OSD_CW = 6;
    localparam int OSD_GW = 14;
    localparam int OSD_GH = 18;
    localparam logic [OSD_CW-1:0] OSD_NEWLINE = 6'h3F;

    typedef struct packed {
        logic              colour;
        logic [1:0]        scale;
        logic              box;
        logic [OSD_CW-1:0] code;
    } osd_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PRIME,
        ST_DRAW,
        ST_BLANK
    } osd_state_e;
endpackage

// File: rtl/osd_dpram.sv
module osd_dpram #(
    parameter int AW = 7,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    output logic active,
    output logic prev
);
    assign active = pol ? raw : ~raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= active;
        end
    end
endmodule

// File: rtl/osd_row_track.sv
module osd_row_track #(
    parameter int AW = 7,
    parameter int GH = 18,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic          mark_tall,
    input  logic          base_load,
    input  logic [AW-1:0] base_val,
    output logic [LW-1:0] line_cnt,
    output logic [AW-1:0] start_base
);
    localparam logic [LW-1:0] LAST_SHORT = LW'(GH - 1);
    localparam logic [LW-1:0] LAST_TALL  = LW'(2 * GH - 1);

    logic          first_q;
    logic          tall_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] next_q;
    logic          row_end;

    assign row_end    = (line_cnt == (tall_q ? LAST_TALL : LAST_SHORT));
    assign start_base = first_q ? '0 : (row_end ? next_q : base_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= 1'b1;
            tall_q   <= 1'b0;
            line_cnt <= '0;
            base_q   <= '0;
            next_q   <= '0;
        end else begin
            if (frame_start) begin
                first_q  <= 1'b1;
                tall_q   <= 1'b0;
                line_cnt <= '0;
                base_q   <= '0;
                next_q   <= '0;
            end else if (line_start) begin
                if (first_q) begin
                    first_q  <= 1'b0;
                    tall_q   <= 1'b0;
                    line_cnt <= '0;
                end else if (row_end) begin
                    tall_q   <= 1'b0;
                    line_cnt <= '0;
                    base_q   <= next_q;
                end else begin
                    line_cnt <= line_cnt + 1'b1;
                end
            end else if (mark_tall) begin
                tall_q <= 1'b1;
            end
            if (!frame_start && base_load) begin
                next_q <= base_val;
            end
        end
    end
endmodule

// File: rtl/osd_row_render.sv
module osd_row_render
    import osd_pkg::*;
#(
    parameter int AW = OSD_AW,
    parameter int GW = OSD_GW,
    parameter int GH = OSD_GH
) (
    input  logic                              dot_clk,
    input  logic                              rst_n,
    input  logic                              hsync_in,
    input  logic                              vsync_in,
    input  logic                              hs_pol,
    input  logic                              vs_pol,
    input  logic                              fg_pol,
    input  logic                              bg_pol,
    input  logic                              cpu_we,
    input  logic [AW-1:0]                     cpu_addr,
    input  logic [$bits(osd_word_t)-1:0]      cpu_wdata,
    output logic [OSD_CW+$clog2(GH)-1:0]      glyph_addr,
    input  logic [GW-1:0]                     glyph_bits,
    output logic                              fg_out,
    output logic                              bg_en_out,
    output logic                              bg_idx,
    output logic                              vsync_irq
);
    localparam int WW  = $bits(osd_word_t);
    localparam int LW  = $clog2(2 * GH);
    localparam int GLW = $clog2(GH);
    localparam int DCW = $clog2(2 * GW);
    localparam int IW  = $clog2(GW);
    localparam logic [DCW-1:0] LAST_NARROW = DCW'(GW - 1);
    localparam logic [DCW-1:0] LAST_WIDE   = DCW'(2 * GW - 1);
    localparam logic [1:0]     PRIME_DONE  = 2'd2;

    osd_state_e state, state_nx;

    logic          hs_act, hs_prev, vs_act, vs_prev;
    logic          hs_lead, hs_trail, vs_lead, line_go;
    logic [AW-1:0] rd_addr;
    logic [WW-1:0] ram_q;
    osd_word_t     rd_word;
    logic [LW-1:0] line_cnt;
    logic [AW-1:0] start_base;
    logic [LW-1:0] gline_full;
    logic          fetch_tall, fetch_blank, is_nl;
    logic          load_ev, do_load, nl_hit, mark_tall, base_load;
    logic [AW-1:0] base_val;
    logic [1:0]    prime_cnt;
    logic [DCW-1:0] dot_cnt, last_dot, dot_idx;
    logic [GW-1:0] cur_bits;
    logic          cur_box, cur_colour, cur_wide, cur_blank;
    logic          fg_act, bg_act, idx_act;

    osd_sync_edge i_hs_edge (
        .clk(dot_clk), .rst_n(rst_n), .raw(hsync_in), .pol(hs_pol),
        .active(hs_act), .prev(hs_prev)
    );

    osd_sync_edge i_vs_edge (
        .clk(dot_clk), .rst_n(rst_n), .raw(vsync_in), .pol(vs_pol),
        .active(vs_act), .prev(vs_prev)
    );

    assign hs_lead  = hs_act & ~hs_prev;
    assign hs_trail = ~hs_act & hs_prev;
    assign vs_lead  = vs_act & ~vs_prev;
    assign line_go  = hs_trail & ~vs_act;

    osd_dpram #(.AW(AW), .DW(WW)) i_disp_mem (
        .clk(dot_clk), .we(cpu_we), .waddr(cpu_addr), .wdata(cpu_wdata),
        .raddr(rd_addr), .rdata(ram_q)
    );

    assign rd_word = ram_q;

    osd_row_track #(.AW(AW), .GH(GH), .LW(LW)) i_row_track (
        .clk(dot_clk), .rst_n(rst_n),
        .frame_start(vs_lead), .line_start(line_go),
        .mark_tall(mark_tall), .base_load(base_load), .base_val(base_val),
        .line_cnt(line_cnt), .start_base(start_base)
    );

    // glyph line of the pending word, used both for the address and the blank test
    assign fetch_tall  = (rd_word.scale != 2'b00);
    assign gline_full  = fetch_tall ? (line_cnt >> 1) : line_cnt;
    assign fetch_blank = (gline_full >= LW'(GH));
    assign glyph_addr  = {rd_word.code, gline_full[GLW-1:0]};
    assign is_nl       = (rd_word.code == OSD_NEWLINE);

    assign last_dot = cur_wide ? LAST_WIDE : LAST_NARROW;
    assign load_ev  = ((state == ST_PRIME) && (prime_cnt == PRIME_DONE)) ||
                      ((state == ST_DRAW) && (dot_cnt == last_dot));
    assign do_load  = load_ev & ~is_nl & ~hs_act & ~vs_act;
    assign nl_hit   = load_ev & is_nl & ~hs_act & ~vs_act;
    assign mark_tall = do_load & (line_cnt == '0) & fetch_tall;
    assign base_load = nl_hit | (hs_lead & ~vs_act & (state == ST_DRAW));
    assign base_val  = nl_hit ? (rd_addr + 1'b1) : rd_addr;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (vs_act) begin
            state_nx = ST_IDLE;
        end else if (hs_act) begin
            state_nx = ST_SYNC;
        end else begin
            unique case (state)
                ST_IDLE, ST_SYNC: begin
                    if (line_go) state_nx = ST_PRIME;
                end
                ST_PRIME: begin
                    if (prime_cnt == PRIME_DONE) state_nx = is_nl ? ST_BLANK : ST_DRAW;
                end
                ST_DRAW: begin
                    if (dot_cnt == last_dot && is_nl) state_nx = ST_BLANK;
                end
                ST_BLANK: state_nx = ST_BLANK;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge dot_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // fetch and character datapath
    always_ff @(posedge dot_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr    <= '0;
            prime_cnt  <= '0;
            dot_cnt    <= '0;
            cur_bits   <= '0;
            cur_box    <= 1'b0;
            cur_colour <= 1'b0;
            cur_wide   <= 1'b0;
            cur_blank  <= 1'b0;
            vsync_irq  <= 1'b0;
        end else begin
            vsync_irq <= vs_lead;
            if (line_go) begin
                rd_addr   <= start_base;
                prime_cnt <= '0;
            end else if (state == ST_PRIME && prime_cnt != PRIME_DONE) begin
                prime_cnt <= prime_cnt + 1'b1;
            end
            if (do_load) begin
                rd_addr    <= rd_addr + 1'b1;
                dot_cnt    <= '0;
                cur_bits   <= glyph_bits;
                cur_box    <= rd_word.box & ~fetch_blank;
                cur_colour <= rd_word.colour;
                cur_wide   <= rd_word.scale[1];
                cur_blank  <= fetch_blank;
            end else if (state == ST_DRAW) begin
                dot_cnt <= dot_cnt + 1'b1;
            end
        end
    end

    assign dot_idx = cur_wide ? (dot_cnt >> 1) : dot_cnt;

    // outputs
    always_comb begin
        fg_act  = 1'b0;
        bg_act  = 1'b0;
        idx_act = 1'b0;
        unique case (state)
            ST_DRAW: begin
                fg_act  = ~cur_blank & cur_bits[IW'(GW - 1) - dot_idx[IW-1:0]];
                bg_act  = cur_box;
                idx_act = cur_box & cur_colour;
            end
            ST_IDLE, ST_SYNC, ST_PRIME, ST_BLANK: begin
                fg_act  = 1'b0;
                bg_act  = 1'b0;
                idx_act = 1'b0;
            end
            default: begin
                fg_act  = 1'b0;
                bg_act  = 1'b0;
                idx_act = 1'b0;
            end
        endcase
        fg_out    = fg_pol ? fg_act : ~fg_act;
        bg_en_out = bg_pol ? bg_act : ~bg_act;
        bg_idx    = idx_act;
    end
endmodule

// File: rtl/osd_row_render_chk.sv
module osd_row_render_chk
    import osd_pkg::*;
#(
    parameter int GH = OSD_GH,
    parameter int LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync_in,
    input logic          vsync_in,
    input logic          hs_pol,
    input logic          vs_pol,
    input logic          fg_pol,
    input logic          bg_pol,
    input logic          fg_out,
    input logic          bg_en_out,
    input logic          bg_idx,
    input logic          vsync_irq,
    input osd_state_e    state,
    input logic [1:0]    prime_cnt,
    input logic [LW-1:0] line_cnt
);
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |=> !vsync_irq); // R9

    AST_VS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_in == vs_pol) |=> (fg_out != fg_pol) && (bg_en_out != bg_pol)); // R9

    AST_HS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_in == hs_pol) |=> (fg_out != fg_pol) && (bg_en_out != bg_pol)); // R10

    AST_BGIDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_en_out != bg_pol) |-> !bg_idx); // R7

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt < LW'(2 * GH)); // R5

    AST_PRIME_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME && prime_cnt == 2'd2 && hsync_in != hs_pol && vsync_in != vs_pol)
        |=> (state == ST_DRAW || state == ST_BLANK)); // R2
endmodule

bind osd_row_render osd_row_render_chk #(.GH(GH), .LW(LW)) i_chk (
    .clk(dot_clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .fg_pol(fg_pol), .bg_pol(bg_pol),
    .fg_out(fg_out), .bg_en_out(bg_en_out), .bg_idx(bg_idx), .vsync_irq(vsync_irq),
    .state(state), .prime_cnt(prime_cnt), .line_cnt(line_cnt)
);

// File: tb/test_osd_row_render.sv
`timescale 1ns/1ps
module test_osd_row_render;
    localparam int CLK_NS    = 20;
    localparam int LINE_DOTS = 90;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_in = 1'b0, vsync_in = 1'b0;
    logic        hs_pol = 1'b1, vs_pol = 1'b1, fg_pol = 1'b1, bg_pol = 1'b1;
    logic        cpu_we = 1'b0;
    logic [6:0]  cpu_addr = '0;
    logic [9:0]  cpu_wdata = '0;
    logic [10:0] glyph_addr;
    logic [13:0] glyph_bits;
    logic        fg_out, bg_en_out, bg_idx, vsync_irq;

    logic [9:0]  mirror [128];
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    osd_row_render i_osd_row_render (
        .dot_clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .fg_pol(fg_pol), .bg_pol(bg_pol),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .glyph_addr(glyph_addr), .glyph_bits(glyph_bits),
        .fg_out(fg_out), .bg_en_out(bg_en_out), .bg_idx(bg_idx), .vsync_irq(vsync_irq)
    );

    function automatic logic [13:0] gfn(input logic [5:0] code, input logic [4:0] gl);
        return {code, gl, code[2:0]};
    endfunction

    always_ff @(posedge clk) glyph_bits <= gfn(glyph_addr[10:5], glyph_addr[4:0]);

    function automatic logic [9:0] wd(input int code, input int scale, input bit box, input bit col);
        logic [5:0] c;
        logic [1:0] s;
        c = code[5:0];
        s = scale[1:0];
        return {col, s, box, c};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [9:0] d);
        @(negedge clk);
        cpu_we = 1'b1;
        cpu_addr = a[6:0];
        cpu_wdata = d;
        mirror[a] = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    function automatic int outs_blank_code();
        return {29'd0, fg_pol ? 1'b0 : 1'b1, bg_pol ? 1'b0 : 1'b1, 1'b0};
    endfunction

    task automatic do_vsync(input string req);
        @(negedge clk);
        vsync_in = vs_pol;
        @(negedge clk);
        chk(vsync_irq == 1'b1, req, "irq after vsync edge", int'(vsync_irq), 1);
        chk({fg_out, bg_en_out, bg_idx} == 3'(outs_blank_code()), req, "blank in vsync",
            int'({fg_out, bg_en_out, bg_idx}), outs_blank_code());
        @(negedge clk);
        chk(vsync_irq == 1'b0, req, "irq one cycle", int'(vsync_irq), 0);
        vsync_in = ~vs_pol;
        repeat (3) @(negedge clk);
    endtask

    // one scan line: hsync pulse, then compare 90 dots against the model
    task automatic run_line(input int base, input int lno, input string req);
        int k, pos, width, gl, bidx, bad_cyc, bad_act, bad_exp;
        bit done, tall, blank, fg, bg, ix;
        logic [9:0] w;
        logic [2:0] expv, actv;
        @(negedge clk);
        hsync_in = hs_pol;
        @(negedge clk);
        @(negedge clk);
        chk({fg_out, bg_en_out, bg_idx} == 3'(outs_blank_code()), "R10", "blank in hsync",
            int'({fg_out, bg_en_out, bg_idx}), outs_blank_code());
        @(negedge clk);
        hsync_in = ~hs_pol;
        repeat (4) @(posedge clk);
        k = base;
        pos = 0;
        w = mirror[k];
        done = (w[5:0] == 6'h3F);
        bad_cyc = -1;
        bad_act = 0;
        bad_exp = 0;
        for (int c = 0; c < LINE_DOTS; c++) begin
            @(negedge clk);
            fg = 1'b0;
            bg = 1'b0;
            ix = 1'b0;
            if (!done) begin
                width = w[8] ? 28 : 14;
                tall  = (w[8:7] != 2'b00);
                gl    = tall ? lno / 2 : lno;
                blank = (gl >= 18);
                bidx  = w[8] ? pos / 2 : pos;
                fg    = !blank && gfn(w[5:0], gl[4:0])[13 - bidx];
                bg    = w[6] && !blank;
                ix    = bg && w[9];
                pos++;
                if (pos == width) begin
                    k = (k + 1) % 128;
                    w = mirror[k];
                    pos = 0;
                    done = (w[5:0] == 6'h3F);
                end
            end
            expv = {fg_pol ? fg : ~fg, bg_pol ? bg : ~bg, ix};
            actv = {fg_out, bg_en_out, bg_idx};
            if (actv !== expv && bad_cyc < 0) begin
                bad_cyc = c;
                bad_act = int'(actv);
                bad_exp = int'(expv);
            end
        end
        chk(bad_cyc < 0, req, $sformatf("line %0d base %0d dots at cycle %0d", lno, base, bad_cyc),
            bad_act, bad_exp);
    endtask

    task automatic t_reset();
        chk({fg_out, bg_en_out, bg_idx, vsync_irq} == 4'b0000, "R1", "reset outputs",
            int'({fg_out, bg_en_out, bg_idx, vsync_irq}), 0);
    endtask

    task automatic t_normal();
        wr(0, wd(1, 0, 0, 0));
        wr(1, wd(2, 0, 0, 0));
        wr(2, wd(3, 0, 0, 0));
        wr(3, wd(63, 0, 0, 0));
        wr(4, wd(4, 0, 1, 1));
        wr(5, wd(5, 0, 1, 0));
        wr(6, wd(63, 0, 0, 0));
        do_vsync("R9");
        for (int l = 0; l < 18; l++) run_line(0, l, "R2 R4");
        for (int l = 0; l < 18; l++) run_line(4, l, "R3 R7");
    endtask

    task automatic t_tall_wide();
        wr(0, wd(7, 1, 0, 0));
        wr(1, wd(8, 0, 1, 0));
        wr(2, wd(63, 0, 0, 0));
        wr(3, wd(9, 2, 1, 1));
        wr(4, wd(10, 0, 0, 0));
        wr(5, wd(63, 0, 0, 0));
        do_vsync("R9");
        run_line(0, 0, "R9");
        for (int l = 1; l < 36; l++) run_line(0, l, "R5");
        for (int l = 0; l < 36; l++) run_line(3, l, "R6");
    endtask

    task automatic t_cpu_write();
        wr(0, wd(12, 0, 0, 0));
        wr(1, wd(13, 0, 0, 0));
        wr(2, wd(63, 0, 0, 0));
        do_vsync("R9");
        run_line(0, 0, "R11");
        wr(1, wd(14, 0, 1, 1));
        run_line(0, 1, "R11");
        wr(0, wd(63, 0, 0, 0));
        run_line(0, 2, "R3");
    endtask

    task automatic t_polarity();
        @(negedge clk);
        hs_pol = 1'b0; hsync_in = 1'b1;
        vs_pol = 1'b0; vsync_in = 1'b1;
        fg_pol = 1'b0; bg_pol = 1'b0;
        wr(0, wd(21, 0, 1, 0));
        wr(1, wd(22, 0, 0, 0));
        wr(2, wd(63, 0, 0, 0));
        @(negedge clk);
        chk({fg_out, bg_en_out} == 2'b11, "R8", "idle outputs active-low", int'({fg_out, bg_en_out}), 3);
        do_vsync("R8");
        for (int l = 0; l < 3; l++) run_line(0, l, "R8");
    endtask

    initial begin
        #(CLK_NS * 150000);
        chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int a = 0; a < 128; a++) wr(a, wd(63, 0, 0, 0));
        t_normal();
        t_tall_wide();
        t_cpu_write();
        t_polarity();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule